// File: doc/BRIEF.md
# Masked Content-Addressable Search Array

This block holds a small array of entries. Each entry stores a data word and a two-bit validity type. A search compares a comparand word against every entry at the same time. A per-bit mask turns chosen bit positions into don't-cares. Only entries of one validity type take part in a search. The per-entry match lines then go through a priority encoder. The result is a match flag, a multiple-match flag and the lowest matching address. These are held until the next search or until the active context is switched.

A second priority encoder runs over the empty-type entries. It gives the lowest free slot and a full indication, so software can place new entries without scanning. Entries are written through a simple write port that carries data and type. A read port returns an entry's data and copies its validity type into a status output.

A small state machine owns the result. Its states are `ST_IDLE` (no result since reset or the last context switch), `ST_HIT` and `ST_MISS`. Its transitions are:

- `T_SWITCH`: any state to `ST_IDLE` when `ctx_switch` is high.
- `T_FOUND`: any state to `ST_HIT` on a search with at least one match.
- `T_NONE`: any state to `ST_MISS` on a search with no match.
- `T_KEEP`: stay in the current state otherwise.

Top module: `cam_search`

## Requirements
- R1: After reset every entry has type empty and data zero. `hit`, `hit_multi` and `hit_addr` are 0, `free_addr` is 0 and `full` is 0.
- R2: When `srch_go` is high and `srch_force` is low at a rising edge, only entries of type valid (code 2'b00) are searched. The result appears on the outputs after that edge.
- R3: When `srch_force` is high, only entries whose type equals `srch_type` are searched. The codes are valid=2'b00, empty=2'b01, skip=2'b10 and ram=2'b11.
- R4: A mask bit of 1 in `srch_mask` makes that bit position a don't-care for every entry.
- R5: When several entries match, `hit_addr` is the lowest-numbered matching entry.
- R6: `hit_multi` is 1 exactly when two or more entries matched the last search. `hit` is then also 1.
- R7: A search with no matching entry gives `hit`=0, `hit_multi`=0 and `hit_addr`=0.
- R8: `ctx_switch` high at an edge clears `hit`, `hit_multi` and `hit_addr`. It wins over a `srch_go` in the same cycle.
- R9: `rd_en` at an edge loads `rd_data` with the addressed entry's data and `rd_status` with its type code, both after that edge.
- R10: `free_addr` is the lowest-numbered entry of type empty. `full` is 1 and `free_addr` is 0 when there is no such entry. Both follow an entry write after the write edge.
- R11: The search result stays unchanged while neither `srch_go` nor `ctx_switch` is asserted, even when entries are rewritten.
- R12: A search and an entry write at the same edge compare against the entry contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_go | input | 1 | Search strobe |
| srch_force | input | 1 | 1: search the type in `srch_type`; 0: search valid entries |
| srch_type | input | 2 | Target validity type for a forced search |
| srch_key | input | WIDTH | Comparand |
| srch_mask | input | WIDTH | Don't-care mask, 1 = ignore bit |
| ctx_switch | input | 1 | Context switch, clears the result |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | AW | Entry write address |
| wr_data | input | WIDTH | Entry write data |
| wr_type | input | 2 | Entry write validity type |
| rd_en | input | 1 | Entry read strobe |
| rd_addr | input | AW | Entry read address |
| rd_data | output | WIDTH | Data of the last read entry |
| rd_status | output | 2 | Validity type of the last read entry |
| hit | output | 1 | Last search found a match |
| hit_multi | output | 1 | Last search found two or more matches |
| hit_addr | output | AW | Lowest matching address, 0 on no match |
| free_addr | output | AW | Lowest empty-type entry, 0 when full |
| full | output | 1 | No empty-type entry exists |

## Verification
The checker assumes a few things about the inputs:
- `srch_go` and `ctx_switch` are the only events that may change the result.
- Reset is held long enough to clear every entry.
- `rd_addr` and `wr_addr` stay below the entry count.

The stimulus keeps to these assumptions. It drives every input on the falling edge and holds it through one rising edge. It then drops the strobes, so each search, write and read is a single-cycle event. It only addresses entries 0 to 7 of the default eight-entry array.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [1:0] {
        VT_VALID = 2'b00,
        VT_EMPTY = 2'b01,
        VT_SKIP  = 2'b10,
        VT_RAM   = 2'b11
    } vtype_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HIT  = 2'b01,
        ST_MISS = 2'b10
    } res_state_e;
endpackage

// File: rtl/cam_entry_array.sv
module cam_entry_array
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [1:0]         wr_type,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    input  logic [WIDTH-1:0]   key,
    input  logic [WIDTH-1:0]   mask,
    input  logic [1:0]         want_type,
    output logic [ENTRIES-1:0] match_vec,
    output logic [ENTRIES-1:0] empty_vec,
    output logic [WIDTH-1:0]   rd_data,
    output logic [1:0]         rd_type
);
    logic [WIDTH-1:0] ent_data [ENTRIES];
    vtype_e           ent_type [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic sel;
        logic [WIDTH-1:0] diff;

        assign sel  = wr_en && (wr_addr == AW'(i));
        assign diff = (ent_data[i] ^ key) & ~mask;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_data[i] <= '0;
                ent_type[i] <= VT_EMPTY;
            end else if (sel) begin
                ent_data[i] <= wr_data;
                ent_type[i] <= vtype_e'(wr_type);
            end
        end

        assign match_vec[i] = (ent_type[i] == vtype_e'(want_type)) && (diff == '0);
        assign empty_vec[i] = (ent_type[i] == VT_EMPTY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_type <= VT_EMPTY;
        end else if (rd_en) begin
            rd_data <= ent_data[rd_addr];
            rd_type <= ent_type[rd_addr];
        end
    end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic          multi,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any   = |vec;
    assign multi = |(vec & (vec - 1'b1));
endmodule

// File: rtl/cam_result_fsm.sv
module cam_result_fsm
    import cam_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          clr,
    input  logic          found,
    input  logic          found_multi,
    input  logic [AW-1:0] found_idx,
    output logic          hit,
    output logic          hit_multi,
    output logic [AW-1:0] hit_addr
);
    res_state_e    state_q, state_d;
    logic          multi_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr)        state_d = ST_IDLE;
        else if (go)    state_d = found ? ST_HIT : ST_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            multi_q <= 1'b0;
            addr_q  <= '0;
        end else if (go) begin
            multi_q <= found && found_multi;
            addr_q  <= found ? found_idx : '0;
        end
    end

    always_comb begin
        hit       = 1'b0;
        hit_multi = 1'b0;
        hit_addr  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                hit       = 1'b1;
                hit_multi = multi_q;
                hit_addr  = addr_q;
            end
            ST_MISS: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/cam_search.sv
module cam_search
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_go,
    input  logic             srch_force,
    input  logic [1:0]       srch_type,
    input  logic [WIDTH-1:0] srch_key,
    input  logic [WIDTH-1:0] srch_mask,
    input  logic             ctx_switch,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       wr_type,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic [1:0]       rd_status,
    output logic             hit,
    output logic             hit_multi,
    output logic [AW-1:0]    hit_addr,
    output logic [AW-1:0]    free_addr,
    output logic             full
);
    logic [1:0]         want_type;
    logic [ENTRIES-1:0] match_vec, empty_vec;
    logic               m_any, m_multi, e_any, e_multi;
    logic [AW-1:0]      m_idx, e_idx;

    assign want_type = srch_force ? srch_type : VT_VALID;

    cam_entry_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_type(wr_type),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .key(srch_key), .mask(srch_mask), .want_type(want_type),
        .match_vec(match_vec), .empty_vec(empty_vec),
        .rd_data(rd_data), .rd_type(rd_status)
    );

    cam_prio_enc #(.N(ENTRIES)) u_match_enc (
        .vec(match_vec), .any(m_any), .multi(m_multi), .idx(m_idx)
    );

    cam_prio_enc #(.N(ENTRIES)) u_free_enc (
        .vec(empty_vec), .any(e_any), .multi(e_multi), .idx(e_idx)
    );

    cam_result_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(srch_go), .clr(ctx_switch),
        .found(m_any), .found_multi(m_multi), .found_idx(m_idx),
        .hit(hit), .hit_multi(hit_multi), .hit_addr(hit_addr)
    );

    logic unused_e_multi;
    assign unused_e_multi = e_multi;

    assign full      = !e_any;
    assign free_addr = e_any ? e_idx : '0;
endmodule

// File: rtl/cam_search_chk.sv
module cam_search_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srch_go,
    input logic          ctx_switch,
    input logic          hit,
    input logic          hit_multi,
    input logic [AW-1:0] hit_addr,
    input logic [AW-1:0] free_addr,
    input logic          full
);
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_addr == '0) && !hit_multi);

    assert_multi_has_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_multi |-> hit);

    assert_switch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> !hit && !hit_multi && (hit_addr == '0));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!srch_go && !ctx_switch) |=> $stable(hit) && $stable(hit_multi) && $stable(hit_addr));

    assert_full_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_addr == '0));
endmodule

bind cam_search cam_search_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_go(srch_go), .ctx_switch(ctx_switch),
    .hit(hit), .hit_multi(hit_multi), .hit_addr(hit_addr),
    .free_addr(free_addr), .full(full)
);

// File: tb/tb_cam_search.sv
module tb_cam_search;
    localparam int ENTRIES = 8;
    localparam int WIDTH   = 16;
    localparam int AW      = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic srch_go = 0, srch_force = 0, ctx_switch = 0, wr_en = 0, rd_en = 0;
    logic [1:0] srch_type = 0, wr_type = 0;
    logic [WIDTH-1:0] srch_key = 0, srch_mask = 0, wr_data = 0;
    logic [AW-1:0] wr_addr = 0, rd_addr = 0;
    logic [WIDTH-1:0] rd_data;
    logic [1:0] rd_status;
    logic hit, hit_multi, full;
    logic [AW-1:0] hit_addr, free_addr;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cam_search #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) dut (.*);

    // {force, type[1:0], key[15:0], mask[15:0], exp_hit, exp_multi, exp_addr[2:0]}
    localparam logic [39:0] VEC [10] = '{
        {1'b0, 2'b00, 16'h1234, 16'h0000, 1'b1, 1'b1, 3'd1},  // R2 R5 R6
        {1'b0, 2'b00, 16'hABCD, 16'h0000, 1'b0, 1'b0, 3'd0},  // R2 R7: skip entry ignored
        {1'b1, 2'b10, 16'hABCD, 16'h0000, 1'b1, 1'b0, 3'd3},  // R3 skip
        {1'b1, 2'b11, 16'h5555, 16'h0000, 1'b1, 1'b0, 3'd4},  // R3 ram
        {1'b0, 2'b00, 16'h12AA, 16'h00FF, 1'b1, 1'b1, 3'd1},  // R4
        {1'b0, 2'b00, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 3'd0},  // R4 R5
        {1'b1, 2'b01, 16'h0000, 16'h0000, 1'b1, 1'b0, 3'd6},  // R3 empty
        {1'b0, 2'b00, 16'h0F00, 16'h0000, 1'b1, 1'b0, 3'd7},  // R2
        {1'b0, 2'b00, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 3'd0},  // R2
        {1'b1, 2'b00, 16'h12FF, 16'h0000, 1'b1, 1'b0, 3'd5}   // R3 valid
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [WIDTH-1:0] d, input logic [1:0] t);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; wr_type = t;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic srch(input logic f, input logic [1:0] t, input logic [WIDTH-1:0] k,
                        input logic [WIDTH-1:0] m);
        @(negedge clk);
        srch_go = 1; srch_force = f; srch_type = t; srch_key = k; srch_mask = m;
        @(negedge clk);
        srch_go = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 hit", hit, 0);
        chk("R1 multi", hit_multi, 0);
        chk("R1 addr", hit_addr, 0);
        chk("R1 free", free_addr, 0);
        chk("R1 full", full, 0);

        wr(0, 16'hBEEF, 2'b00);
        wr(1, 16'h1234, 2'b00);
        wr(2, 16'h1234, 2'b00);
        wr(3, 16'hABCD, 2'b10);
        wr(4, 16'h5555, 2'b11);
        wr(5, 16'h12FF, 2'b00);
        wr(7, 16'h0F00, 2'b00);
        chk("R10 free after setup", free_addr, 6);
        chk("R10 not full", full, 0);

        for (int i = 0; i < 10; i++) begin
            srch(VEC[i][39], VEC[i][38:37], VEC[i][36:21], VEC[i][20:5]);
            chk($sformatf("R2-R7 vec%0d hit", i), hit, VEC[i][4]);
            chk($sformatf("R6 vec%0d multi", i), hit_multi, VEC[i][3]);
            chk($sformatf("R5 vec%0d addr", i), hit_addr, VEC[i][2:0]);
        end

        // R11: result held across entry rewrites
        srch(0, 2'b00, 16'h0F00, 16'h0000);
        wr(7, 16'h0000, 2'b10);
        @(negedge clk);
        chk("R11 hit held", hit, 1);
        chk("R11 addr held", hit_addr, 7);
        wr(7, 16'h0F00, 2'b00);

        // R8: switch clears; switch wins over go
        @(negedge clk);
        ctx_switch = 1;
        @(negedge clk);
        ctx_switch = 0;
        chk("R8 clear hit", hit, 0);
        chk("R8 clear addr", hit_addr, 0);
        srch(0, 2'b00, 16'h1234, 16'h0000);
        chk("R8 rehit", hit, 1);
        @(negedge clk);
        ctx_switch = 1; srch_go = 1; srch_force = 0; srch_key = 16'h1234; srch_mask = 0;
        @(negedge clk);
        ctx_switch = 0; srch_go = 0;
        chk("R8 switch wins hit", hit, 0);
        chk("R8 switch wins multi", hit_multi, 0);

        // R9: read copies data and type
        @(negedge clk);
        rd_en = 1; rd_addr = 3;
        @(negedge clk);
        rd_en = 0;
        chk("R9 rd_data", rd_data, 16'hABCD);
        chk("R9 rd_status", rd_status, 2'b10);
        rd_en = 1; rd_addr = 6;
        @(negedge clk);
        rd_en = 0;
        chk("R9 rd_status empty", rd_status, 2'b01);

        // R12: write and search at the same edge see old contents
        @(negedge clk);
        wr_en = 1; wr_addr = 7; wr_data = 16'h7777; wr_type = 2'b00;
        srch_go = 1; srch_force = 0; srch_key = 16'h7777; srch_mask = 0;
        @(negedge clk);
        wr_en = 0; srch_go = 0;
        chk("R12 old contents miss", hit, 0);
        srch(0, 2'b00, 16'h7777, 16'h0000);
        chk("R12 new contents hit", hit, 1);
        chk("R12 new contents addr", hit_addr, 7);

        // R10: full when last empty entry taken
        wr(6, 16'h6666, 2'b11);
        chk("R10 full", full, 1);
        chk("R10 full addr", free_addr, 0);
        wr(2, 16'h0000, 2'b01);
        chk("R10 freed", full, 0);
        chk("R10 freed addr", free_addr, 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule